// File: doc/BRIEF.md
# MII Carrier Sense and Collision Generator

This block produces the carrier-sense and collision outputs that an Ethernet PHY presents on its MII. It takes the PHY's internal receive-activity and transmit-activity flags, a line signal-detect flag and the operating-mode bits: speed, duplex, repeater, symbol and heartbeat enable. From these it forms a registered carrier flag and a registered collision flag, one reference-clock cycle after the inputs they reflect.

In 10 Mb/s half-duplex operation with heartbeat enabled, the block also produces the SQE test pulse. When transmit activity ends, the collision output is held high for a fixed number of reference-clock cycles. That number is set by a parameter, and its default of 25 cycles gives about 1 µs at 25 MHz. Repeater mode, full duplex, 100 Mb/s operation and a cleared enable each suppress the pulse. A new transmission that starts during the pulse cuts it short.

Top module: `mii_crs_col`

## Requirements
- R1: With symbol mode off, half duplex and repeater off, `crs` equals `rx_act | tx_act` sampled at the previous clock edge.
- R2: With symbol mode off and either full duplex or repeater mode on, `crs` equals `rx_act` sampled at the previous edge, and transmit activity alone leaves it low.
- R3: With symbol mode on, `crs` equals `sig_det` sampled at the previous edge, whatever the duplex, repeater or activity inputs are.
- R4: In half duplex at either speed, including repeater and symbol mode, `col` is high one cycle after an edge at which `tx_act` and `rx_act` were both high.
- R5: In full duplex `col` stays low, including after transmit activity ends with heartbeat enabled.
- R6: With `spd_100`=0, `full_dup`=0, `rptr_mode`=0 and `hb_en`=1, a high-to-low change of `tx_act` seen at a clock edge makes `col` high from that edge for exactly `HB_CYC` cycles.
- R7: Repeater mode suppresses the heartbeat pulse even with `hb_en`=1.
- R8: No heartbeat pulse is produced when `hb_en`=0 or when `spd_100`=1.
- R9: If `tx_act` is high at an edge while the heartbeat pulse is active, the pulse ends at that edge, and `col` then shows only the collision condition.
- R10: While `rst_n` is low at a clock edge, `crs` and `col` are low after that edge and any heartbeat pulse is cancelled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_act | input | 1 | Receive activity present |
| tx_act | input | 1 | Transmit activity present |
| sig_det | input | 1 | Line signal detect, active high |
| spd_100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| full_dup | input | 1 | 1 = full duplex |
| rptr_mode | input | 1 | 1 = repeater operation |
| sym_mode | input | 1 | 1 = symbol mode (carrier shows signal detect) |
| hb_en | input | 1 | Heartbeat (SQE test) enable |
| crs | output | 1 | MII carrier sense |
| col | output | 1 | MII collision, heartbeat merged in |

## Verification
The bench builds the block with `HB_CYC` set to 6, not the default 25. This keeps each pulse short enough that its first cycle, its last cycle and the cycle after it are all checked, and it leaves room for several pulse runs, including one cut short in its middle. The counter-width derivation from `HB_CYC` is therefore exercised at a value that is not a power of two minus one. The mode-by-activity table covers both speeds and every carrier source.

// File: rtl/mii_crs_col_pkg.sv
// Package: shared types for the MII carrier/collision generator.
// Assumes: all mode bits are static or change only between frames.
package mii_crs_col_pkg;

    // Source chosen for the carrier output.
    typedef enum logic [1:0] {
        CRS_SRC_BOTH = 2'd0,  // receive or transmit activity
        CRS_SRC_RX   = 2'd1,  // receive activity only
        CRS_SRC_SDET = 2'd2   // line signal detect
    } crs_src_e;

    // Mode controls bundled for the submodules.
    typedef struct packed {
        logic spd_100;
        logic full_dup;
        logic rptr;
        logic sym;
        logic hb_en;
    } mode_t;

endpackage

// File: rtl/mii_crs_sel.sv
// Module: carrier sense selector.
// Picks the carrier source from the mode and registers the result.
// Assumes: inputs are synchronous to clk; output lags inputs by one cycle.
module mii_crs_sel
    import mii_crs_col_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  mode_t mode,
    input  logic  rx_act,
    input  logic  tx_act,
    input  logic  sig_det,
    output logic  crs
);

    crs_src_e src;
    logic     crs_d;

    // Choose the carrier source: symbol mode wins, then full duplex or repeater.
    always_comb begin
        if (mode.sym)
            src = CRS_SRC_SDET;
        else if (mode.full_dup || mode.rptr)
            src = CRS_SRC_RX;
        else
            src = CRS_SRC_BOTH;
    end

    // Form the next carrier value from the chosen source.
    always_comb begin
        unique case (src)
            CRS_SRC_SDET: crs_d = sig_det;
            CRS_SRC_RX:   crs_d = rx_act;
            default:      crs_d = rx_act | tx_act;
        endcase
    end

    // Register the carrier output; reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) crs <= 1'b0;
        else        crs <= crs_d;
    end

    // R3
    sym_crs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode.sym |=> (crs == $past(sig_det)));

    // R2
    rx_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode.sym && (mode.full_dup || mode.rptr) && !rx_act) |=> !crs);

endmodule

// File: rtl/mii_col_det.sv
// Module: collision detector.
// Flags simultaneous transmit and receive activity in half duplex.
// Assumes: activity flags are synchronous; output lags them by one cycle.
module mii_col_det
    import mii_crs_col_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  mode_t mode,
    input  logic  rx_act,
    input  logic  tx_act,
    output logic  coll
);

    // Register the collision flag; full duplex forces it low.
    always_ff @(posedge clk) begin
        if (!rst_n) coll <= 1'b0;
        else        coll <= !mode.full_dup && rx_act && tx_act;
    end

    // R5
    fd_no_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode.full_dup |=> !coll);

    // R4
    hd_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode.full_dup && rx_act && tx_act) |=> coll);

endmodule

// File: rtl/mii_sqe_timer.sv
// Module: heartbeat (SQE test) pulse timer.
// Sees the end of a transmission and holds a pulse for HB_CYC clock cycles.
// Assumes: HB_CYC >= 1; the pulse starts at the edge that sees tx_act low
// after high.
module mii_sqe_timer
    import mii_crs_col_pkg::*;
#(
    parameter int HB_CYC = 25
) (
    input  logic  clk,
    input  logic  rst_n,
    input  mode_t mode,
    input  logic  tx_act,
    output logic  sqe
);

    localparam int CNT_W = (HB_CYC > 1) ? $clog2(HB_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HB_CYC - 1);

    logic             tx_q;
    logic [CNT_W-1:0] cnt;
    logic             hb_ok;
    logic             start;

    // Heartbeat is allowed only at 10 Mb/s, half duplex, not repeating, enabled.
    assign hb_ok = mode.hb_en && !mode.spd_100 && !mode.full_dup && !mode.rptr;
    assign start = hb_ok && tx_q && !tx_act;

    // Keep last cycle's transmit activity for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) tx_q <= 1'b0;
        else        tx_q <= tx_act;
    end

    // Load, count down and end the pulse; new transmit or lost mode aborts it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sqe <= 1'b0;
            cnt <= '0;
        end else if (start) begin
            sqe <= 1'b1;
            cnt <= LAST;
        end else if (sqe) begin
            if (tx_act || !hb_ok || cnt == '0) begin
                sqe <= 1'b0;
                cnt <= '0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // R6
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> sqe);

    // R9
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sqe && tx_act) |=> !sqe);

    // R7
    rptr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode.rptr |=> !sqe);

endmodule

// File: rtl/mii_crs_col.sv
// Module: MII carrier sense and collision generator (top).
// Registers CRS and COL from activity and mode inputs; merges the heartbeat
// pulse onto COL. Assumes: one free-running clock, synchronous active-low reset.
module mii_crs_col
    import mii_crs_col_pkg::*;
#(
    parameter int HB_CYC = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_act,
    input  logic tx_act,
    input  logic sig_det,
    input  logic spd_100,
    input  logic full_dup,
    input  logic rptr_mode,
    input  logic sym_mode,
    input  logic hb_en,
    output logic crs,
    output logic col
);

    mode_t mode;
    logic  coll;
    logic  sqe;

    // Bundle the mode pins for the submodules.
    assign mode = '{spd_100: spd_100, full_dup: full_dup, rptr: rptr_mode,
                    sym: sym_mode, hb_en: hb_en};

    mii_crs_sel u_crs (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .rx_act(rx_act), .tx_act(tx_act), .sig_det(sig_det), .crs(crs)
    );

    mii_col_det u_col (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .rx_act(rx_act), .tx_act(tx_act), .coll(coll)
    );

    mii_sqe_timer #(.HB_CYC(HB_CYC)) u_sqe (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .tx_act(tx_act), .sqe(sqe)
    );

    // Merge the heartbeat pulse onto the collision output.
    assign col = coll | sqe;

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!crs && !col));

    // R5
    fd_col_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full_dup && $past(full_dup)) |-> !col);

endmodule

// File: tb/mii_crs_col_test.sv
module mii_crs_col_test;

    localparam int HB = 6;
    localparam int NV = 14;
    // {spd_100, full_dup, rptr, sym, rx, tx, sig, exp_crs, exp_col}; hb_en = 0
    localparam logic [8:0] VEC [NV] = '{
        9'b0000_000_00,  // R1 idle
        9'b0000_100_10,  // R1 rx only
        9'b0000_010_10,  // R1 tx only
        9'b0000_110_11,  // R4 10M collision
        9'b1000_110_11,  // R4 100M collision
        9'b1000_010_10,  // R1 100M tx only
        9'b1100_110_10,  // R5 100M full duplex
        9'b0100_010_00,  // R2 full duplex tx only
        9'b0010_010_00,  // R2 repeater tx only
        9'b0010_110_11,  // R2 R4 repeater collision
        9'b0001_001_10,  // R3 symbol, signal
        9'b0001_110_01,  // R3 R4 symbol, no signal
        9'b0101_011_10,  // R3 symbol full duplex
        9'b0100_100_10   // R2 10M full duplex rx
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_act = 1'b0, tx_act = 1'b0, sig_det = 1'b0;
    logic spd_100 = 1'b0, full_dup = 1'b0, rptr_mode = 1'b0;
    logic sym_mode = 1'b0, hb_en = 1'b0;
    logic crs, col;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    mii_crs_col #(.HB_CYC(HB)) uut (
        .clk(clk), .rst_n(rst_n), .rx_act(rx_act), .tx_act(tx_act),
        .sig_det(sig_det), .spd_100(spd_100), .full_dup(full_dup),
        .rptr_mode(rptr_mode), .sym_mode(sym_mode), .hb_en(hb_en),
        .crs(crs), .col(col)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // Advance one edge and land on the following falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_mode(input logic s, input logic f, input logic r,
                            input logic y, input logic h);
        spd_100 = s; full_dup = f; rptr_mode = r; sym_mode = y; hb_en = h;
    endtask

    // Run a transmission end and count cycles with col high.
    task automatic tx_end_count(output int hi);
        rx_act = 1'b0;
        tx_act = 1'b1;
        step();
        step();
        tx_act = 1'b0;
        hi = 0;
        for (int k = 0; k < HB + 3; k++) begin
            step();
            if (col) hi++;
        end
    endtask

    initial begin
        int hi;
        @(negedge clk);
        rx_act = 1'b1; tx_act = 1'b1; sig_det = 1'b1;
        step();
        chk(crs, 1'b0, "R10 crs in reset");
        chk(col, 1'b0, "R10 col in reset");
        rx_act = 1'b0; tx_act = 1'b0; sig_det = 1'b0;
        rst_n = 1'b1;
        step();

        for (int i = 0; i < NV; i++) begin
            set_mode(VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5], 1'b0);
            rx_act = VEC[i][4]; tx_act = VEC[i][3]; sig_det = VEC[i][2];
            step();
            chk(crs, VEC[i][1], $sformatf("R1/R2/R3 crs vec %0d", i));
            chk(col, VEC[i][0], $sformatf("R4/R5 col vec %0d", i));
        end
        rx_act = 1'b0; tx_act = 1'b0; sig_det = 1'b0;
        set_mode(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        step();

        // R6: pulse width and exact placement
        set_mode(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        rx_act = 1'b0;
        tx_act = 1'b1;
        step();
        step();
        chk(col, 1'b0, "R6 no col while transmitting");
        tx_act = 1'b0;
        for (int k = 1; k <= HB; k++) begin
            step();
            chk(col, 1'b1, $sformatf("R6 pulse cycle %0d", k));
        end
        step();
        chk(col, 1'b0, "R6 pulse ended");

        // R6 again as a count
        tx_end_count(hi);
        chk(hi == HB, 1'b1, "R6 pulse length");

        // R7 repeater suppresses
        set_mode(1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        tx_end_count(hi);
        chk(hi == 0, 1'b1, "R7 repeater no pulse");

        // R8 disabled, and 100M
        set_mode(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        tx_end_count(hi);
        chk(hi == 0, 1'b1, "R8 hb_en=0 no pulse");
        set_mode(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        tx_end_count(hi);
        chk(hi == 0, 1'b1, "R8 100M no pulse");

        // R5 full duplex with heartbeat enabled
        set_mode(1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        tx_end_count(hi);
        chk(hi == 0, 1'b1, "R5 full duplex no pulse");

        // R9 new transmission cuts the pulse, no collision
        set_mode(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        tx_act = 1'b1;
        step();
        step();
        tx_act = 1'b0;
        step();
        step();
        chk(col, 1'b1, "R9 pulse running");
        tx_act = 1'b1;
        step();
        chk(col, 1'b0, "R9 pulse cut by tx");
        step();
        chk(col, 1'b0, "R9 stays low");

        // R9 cut with collision present: col follows collision
        tx_act = 1'b0;
        step();
        chk(col, 1'b1, "R9 second pulse start");
        tx_act = 1'b1; rx_act = 1'b1;
        step();
        chk(col, 1'b1, "R9 collision shown");
        rx_act = 1'b0;
        step();
        chk(col, 1'b0, "R9 collision gone, pulse gone");

        // R10 reset during pulse
        tx_act = 1'b0;
        step();
        chk(col, 1'b1, "R10 pulse before reset");
        rst_n = 1'b0;
        step();
        chk(col, 1'b0, "R10 pulse cleared by reset");
        rst_n = 1'b1;
        step();
        chk(col, 1'b0, "R10 no pulse after reset");

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule